// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns an operand reference into physical bus requests for a 16-bit machine with a 20-bit address space. Each request supplies an addressing mode, the four pointer registers that modes may draw on, a displacement, an optional segment override, a string-destination flag and the access size. The block works out the 16-bit effective address and chooses the segment register. It forms the physical address by shifting the segment left four bits and adding the effective address. It then issues the access on a simple bus-request output.

The work runs in two stages. The first stage registers the effective address and the chosen segment value. The second stage forms the physical sum and drives the bus. A word that starts on an odd address cannot go out as a single word beat, so the second stage issues it as two byte beats on consecutive cycles. While it does so it holds the input stage back through `in_ready`. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high.

Top module: `seg_addr_unit`

## Requirements
- R1: The physical address is (segment value × 16 + effective address) modulo 2^20, so sums past 0xFFFFF wrap to low addresses.
- R2: The mode code `am_mode` selects the effective address, which is computed modulo 2^16:
  - 1 = base + disp
  - 2 = index + disp
  - 3 = base + index
  - 4 = base + index + disp
  - 5, 6 and 7 = the full 16-bit `disp` taken as a direct offset

  In modes 1, 2 and 4, `disp_wide`=0 uses `disp[7:0]` sign-extended to 16 bits, and `disp_wide`=1 uses all 16 bits. `base_sel` picks the base register (0 = BX, 1 = BP). `index_sel` picks the index register (0 = SI, 1 = DI).
- R3: Mode 0 is register indirect. The effective address is the register named by `ptr_sel`: 0 = SI, 1 = DI, 2 = BX, 3 = BP.
- R4: Without an override or the string flag, the stack segment is used when the effective address includes BP (mode 0 with `ptr_sel`=3, or modes 1, 3 and 4 with `base_sel`=1). Every other case, including the direct modes, uses the data segment.
- R5: When `ovr_en`=1 and `str_dst`=0, `ovr_seg` replaces the default segment: 0 = ES, 1 = CS, 2 = SS, 3 = DS.
- R6: When `str_dst`=1, the extra segment is used whatever the override inputs say.
- R7: A byte access, or a word access at an even physical address, produces exactly one beat with `bus_last`=1. On that beat `bus_word` equals the access size.
- R8: A word access at an odd physical address produces two byte beats on consecutive cycles, both with `bus_word`=0. The first beat is at the address and carries `bus_last`=0. The second is at the address + 1 (modulo 2^20) and carries `bus_last`=1.
- R9: When the block is idle, an accepted request shows its first beat two rising edges after acceptance. `in_ready` goes low only while the first beat of a split word is on the bus and the first stage is occupied.
- R10: While and after synchronous reset (active high), `bus_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge if valid |
| am_mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Register-indirect pointer choice |
| base_sel | input | 1 | Base register choice (0 BX, 1 BP) |
| index_sel | input | 1 | Index register choice (0 SI, 1 DI) |
| disp | input | 16 | Displacement or direct offset |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit sign-extended |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| str_dst | input | 1 | String destination access, forces ES |
| acc_word | input | 1 | 1 = word access, 0 = byte |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| bus_valid | output | 1 | Bus beat present |
| bus_addr | output | 20 | Physical beat address |
| bus_word | output | 1 | Beat is a full word |
| bus_last | output | 1 | Final beat of the request |

## Verification
A wrong segment choice or a bad effective-address sum shows up on `bus_addr` of the very beat that request produces, two edges after acceptance. A split sequencer stuck in the wrong phase shows at the ports in one of two ways. It may repeat or drop a beat, which leaves the expected beat stream misaligned from that cycle on. Or it may hold `in_ready` low while no split first beat is on the bus, which is visible in the same cycle. Directed cases cover both 20-bit wrap points and negative short displacements, so a sign or carry error surfaces on a single beat.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    parameter int OFS_W     = 16;
    parameter int SEG_SHIFT = 4;
    parameter int SHORT_W   = 8;
    parameter int SEG_COUNT = 4;

    localparam int PA_W      = OFS_W + SEG_SHIFT;
    localparam int SEG_SEL_W = $clog2(SEG_COUNT);

    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [PA_W-1:0]  pa_t;

    typedef enum logic [2:0] {
        AM_PTR        = 3'd0,
        AM_BASE       = 3'd1,
        AM_INDEX      = 3'd2,
        AM_BASE_IDX   = 3'd3,
        AM_BASE_IDX_D = 3'd4,
        AM_DIRECT     = 3'd5
    } amode_e;

    typedef enum logic [SEG_SEL_W-1:0] {
        SG_ES = 2'd0,
        SG_CS = 2'd1,
        SG_SS = 2'd2,
        SG_DS = 2'd3
    } seg_e;

    typedef struct packed {
        ofs_t seg;
        ofs_t ea;
        logic word;
    } stage1_t;

    typedef struct packed {
        pa_t  pa;
        logic word;
        logic split;
    } stage2_t;

    function automatic ofs_t widen_disp(input ofs_t d, input logic wide);
        ofs_t r;
        if (wide) r = d;
        else      r = {{(OFS_W-SHORT_W){d[SHORT_W-1]}}, d[SHORT_W-1:0]};
        return r;
    endfunction

    function automatic pa_t phys_of(input ofs_t seg, input ofs_t ea);
        pa_t shifted;
        pa_t offs;
        shifted = {seg, {SEG_SHIFT{1'b0}}};
        offs    = {{SEG_SHIFT{1'b0}}, ea};
        return shifted + offs;
    endfunction

endpackage

// File: rtl/seg_ea_calc.sv
module seg_ea_calc
    import seg_addr_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] ptr_sel,
    input  logic       base_sel,
    input  logic       index_sel,
    input  ofs_t       disp,
    input  logic       disp_wide,
    input  ofs_t       reg_bx,
    input  ofs_t       reg_bp,
    input  ofs_t       reg_si,
    input  ofs_t       reg_di,
    output ofs_t       ea,
    output logic       via_bp
);
    ofs_t   dx;
    ofs_t   base_v;
    ofs_t   index_v;
    ofs_t   ptr_v;
    amode_e md;

    always_comb begin
        md      = amode_e'(mode);
        dx      = widen_disp(disp, disp_wide);
        base_v  = base_sel  ? reg_bp : reg_bx;
        index_v = index_sel ? reg_di : reg_si;
        case (ptr_sel)
            2'd0:    ptr_v = reg_si;
            2'd1:    ptr_v = reg_di;
            2'd2:    ptr_v = reg_bx;
            default: ptr_v = reg_bp;
        endcase

        case (md)
            AM_PTR: begin
                ea     = ptr_v;
                via_bp = (ptr_sel == 2'd3);
            end
            AM_BASE: begin
                ea     = base_v + dx;
                via_bp = base_sel;
            end
            AM_INDEX: begin
                ea     = index_v + dx;
                via_bp = 1'b0;
            end
            AM_BASE_IDX: begin
                ea     = base_v + index_v;
                via_bp = base_sel;
            end
            AM_BASE_IDX_D: begin
                ea     = base_v + index_v + dx;
                via_bp = base_sel;
            end
            default: begin
                ea     = disp;
                via_bp = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  ofs_t [SEG_COUNT-1:0]  bank,
    input  logic                  via_bp,
    input  logic                  ovr_en,
    input  logic [SEG_SEL_W-1:0]  ovr_seg,
    input  logic                  str_dst,
    output ofs_t                  seg_val
);
    seg_e pick;

    always_comb begin
        if (str_dst)     pick = SG_ES;
        else if (ovr_en) pick = seg_e'(ovr_seg);
        else if (via_bp) pick = SG_SS;
        else             pick = SG_DS;
        seg_val = bank[pick];
    end
endmodule

// File: rtl/seg_bus_split.sv
module seg_bus_split
    import seg_addr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    s1_valid,
    input  stage1_t s1,
    output logic    take,
    output logic    bus_valid,
    output pa_t     bus_addr,
    output logic    bus_word,
    output logic    bus_last
);
    stage2_t s2;
    logic    s2_valid;
    logic    second;
    logic    first_of_split;

    assign first_of_split = s2_valid && s2.split && !second;
    assign take           = !first_of_split;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            second   <= 1'b0;
            s2       <= '0;
        end else if (take) begin
            s2_valid <= s1_valid;
            second   <= 1'b0;
            s2.pa    <= phys_of(s1.seg, s1.ea);
            s2.word  <= s1.word;
            s2.split <= s1.word && s1.ea[0];
        end else begin
            second   <= 1'b1;
        end
    end

    always_comb begin
        bus_valid = s2_valid;
        bus_addr  = second ? s2.pa + pa_t'(1) : s2.pa;
        bus_word  = s2.word && !s2.split;
        bus_last  = !(s2.split && !second);
    end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import seg_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [2:0]  am_mode,
    input  logic [1:0]  ptr_sel,
    input  logic        base_sel,
    input  logic        index_sel,
    input  logic [15:0] disp,
    input  logic        disp_wide,
    input  logic        ovr_en,
    input  logic [1:0]  ovr_seg,
    input  logic        str_dst,
    input  logic        acc_word,
    input  logic [15:0] reg_bx,
    input  logic [15:0] reg_bp,
    input  logic [15:0] reg_si,
    input  logic [15:0] reg_di,
    input  logic [15:0] seg_es,
    input  logic [15:0] seg_cs,
    input  logic [15:0] seg_ss,
    input  logic [15:0] seg_ds,
    output logic        bus_valid,
    output logic [19:0] bus_addr,
    output logic        bus_word,
    output logic        bus_last
);
    ofs_t                 ea_c;
    logic                 via_bp_c;
    ofs_t                 seg_c;
    ofs_t [SEG_COUNT-1:0] bank;
    stage1_t              s1;
    logic                 s1_valid;
    logic                 take;

    always_comb begin
        bank[SG_ES] = seg_es;
        bank[SG_CS] = seg_cs;
        bank[SG_SS] = seg_ss;
        bank[SG_DS] = seg_ds;
    end

    seg_ea_calc u_ea (
        .mode      (am_mode),
        .ptr_sel   (ptr_sel),
        .base_sel  (base_sel),
        .index_sel (index_sel),
        .disp      (disp),
        .disp_wide (disp_wide),
        .reg_bx    (reg_bx),
        .reg_bp    (reg_bp),
        .reg_si    (reg_si),
        .reg_di    (reg_di),
        .ea        (ea_c),
        .via_bp    (via_bp_c)
    );

    seg_select u_sel (
        .bank    (bank),
        .via_bp  (via_bp_c),
        .ovr_en  (ovr_en),
        .ovr_seg (ovr_seg),
        .str_dst (str_dst),
        .seg_val (seg_c)
    );

    assign in_ready = !s1_valid || take;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1       <= '0;
        end else if (in_ready) begin
            s1_valid <= in_valid;
            s1.seg   <= seg_c;
            s1.ea    <= ea_c;
            s1.word  <= acc_word;
        end
    end

    seg_bus_split u_split (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1        (s1),
        .take      (take),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_word  (bus_word),
        .bus_last  (bus_last)
    );
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        bus_valid,
    input logic [19:0] bus_addr,
    input logic        bus_word,
    input logic        bus_last
);
    // R8: the beat after a non-final beat is the final one, one address higher
    p_split_follow_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_last) |=> (bus_valid && bus_last &&
                                      bus_addr == 20'($past(bus_addr) + 20'd1)));

    // R8: the first beat of a split is an odd-address byte beat
    p_split_first_odd_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_last) |-> (bus_addr[0] && !bus_word));

    // R7: a word beat is always even and single
    p_word_even_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_word) |-> (!bus_addr[0] && bus_last));

    // R9: back-pressure only during the first half of a split
    p_stall_cause_r9: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (bus_valid && !bus_last));

    // R10: one cycle after reset the bus is idle and input is open
    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> (!bus_valid && in_ready));
endmodule

bind seg_addr_unit seg_addr_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_word  (bus_word),
    .bus_last  (bus_last)
);

// File: tb/seg_addr_unit_test.sv
`timescale 1ns/1ps
module seg_addr_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  am_mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic        base_sel = 1'b0, index_sel = 1'b0, disp_wide = 1'b0;
    logic [15:0] disp = '0;
    logic        ovr_en = 1'b0, str_dst = 1'b0, acc_word = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic        bus_valid, bus_word, bus_last;
    logic [19:0] bus_addr;

    always #2 clk = ~clk;

    seg_addr_unit uut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [19:0] exp_addr [0:8191];
    logic        exp_word [0:8191];
    logic        exp_last [0:8191];
    string       exp_tag  [0:8191];
    int          wr_ptr = 0;
    int          rd_ptr = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_ea(input logic [2:0] md, input logic [1:0] ps,
                                         input logic bs, input logic is_, input logic [15:0] d,
                                         input logic dw);
        logic [15:0] dx, b, x, r;
        dx = dw ? d : {{8{d[7]}}, d[7:0]};
        b  = bs ? reg_bp : reg_bx;
        x  = is_ ? reg_di : reg_si;
        case (md)
            3'd0: case (ps)
                      2'd0: r = reg_si;
                      2'd1: r = reg_di;
                      2'd2: r = reg_bx;
                      default: r = reg_bp;
                  endcase
            3'd1: r = b + dx;
            3'd2: r = x + dx;
            3'd3: r = b + x;
            3'd4: r = b + x + dx;
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] m_seg(input logic [2:0] md, input logic [1:0] ps,
                                          input logic bs, input logic ov, input logic [1:0] os,
                                          input logic st);
        logic uses_bp;
        logic [15:0] r;
        uses_bp = (md == 3'd0) ? (ps == 2'd3) :
                  (md == 3'd1 || md == 3'd3 || md == 3'd4) ? bs : 1'b0;
        if (st) r = seg_es;
        else if (ov) begin
            case (os)
                2'd0: r = seg_es;
                2'd1: r = seg_cs;
                2'd2: r = seg_ss;
                default: r = seg_ds;
            endcase
        end else r = uses_bp ? seg_ss : seg_ds;
        return r;
    endfunction

    task automatic push(input logic [19:0] a, input logic w, input logic l, input string tag);
        exp_addr[wr_ptr] = a;
        exp_word[wr_ptr] = w;
        exp_last[wr_ptr] = l;
        exp_tag[wr_ptr]  = tag;
        wr_ptr++;
    endtask

    task automatic issue(input logic [2:0] md, input logic [1:0] ps, input logic bs,
                         input logic is_, input logic [15:0] d, input logic dw,
                         input logic ov, input logic [1:0] os, input logic st,
                         input logic wd, input string tag);
        logic [15:0] ea, sg;
        logic [19:0] pa;
        am_mode = md; ptr_sel = ps; base_sel = bs; index_sel = is_;
        disp = d; disp_wide = dw; ovr_en = ov; ovr_seg = os; str_dst = st;
        acc_word = wd; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        ea = m_ea(md, ps, bs, is_, d, dw);
        sg = m_seg(md, ps, bs, ov, os, st);
        pa = {sg, 4'b0000} + {4'b0000, ea};
        if (wd && ea[0]) begin
            push(pa, 1'b0, 1'b0, tag);
            push(pa + 20'd1, 1'b0, 1'b1, tag);
        end else begin
            push(pa, wd, 1'b1, tag);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compare every beat with the expected stream
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_valid) begin
                if (rd_ptr >= wr_ptr) begin
                    chk(1'b0, "R7 unexpected beat", {12'd0, bus_addr}, 32'd0);
                end else begin
                    chk(bus_addr == exp_addr[rd_ptr],
                        {exp_tag[rd_ptr], " R1 beat address"}, {12'd0, bus_addr}, {12'd0, exp_addr[rd_ptr]});
                    chk(bus_word == exp_word[rd_ptr] && bus_last == exp_last[rd_ptr],
                        {exp_tag[rd_ptr], " R8 beat word/last"}, {30'd0, bus_word, bus_last},
                        {30'd0, exp_word[rd_ptr], exp_last[rd_ptr]});
                    rd_ptr++;
                end
            end
            if (!in_ready)
                chk(bus_valid && !bus_last, "R9 stall only on split first beat",
                    {30'd0, bus_valid, bus_last}, 32'd2);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL R9 watchdog actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!bus_valid && in_ready, "R10 reset state", {30'd0, bus_valid, in_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_valid && in_ready, "R10 idle after reset", {30'd0, bus_valid, in_ready}, 32'd1);

        seg_es = 16'h4000; seg_cs = 16'h5000; seg_ss = 16'h2000; seg_ds = 16'h1000;
        reg_si = 16'h0100; reg_di = 16'h0202; reg_bx = 16'h0300; reg_bp = 16'h0404;

        // R9: latency with idle pipe
        issue(3'd0, 2'd0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, "R3");
        chk(!bus_valid, "R9 no beat one edge after accept", {31'd0, bus_valid}, 32'd0);
        @(negedge clk);
        chk(bus_valid && bus_addr == 20'h10100, "R9 beat two edges after accept",
            {12'd0, bus_addr}, 32'h10100);
        @(negedge clk);

        // R3: each pointer
        for (int p = 0; p < 4; p++)
            issue(3'd0, 2'(p), 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, "R3 R4");
        // R2: negative short displacement
        reg_bx = 16'h0005;
        issue(3'd1, 2'd0, 1'b0, 1'b0, 16'h0080, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, "R2 sext");
        issue(3'd2, 2'd0, 1'b0, 1'b1, 16'hFFFE, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, "R2 wide");
        issue(3'd4, 2'd0, 1'b1, 1'b1, 16'h00F0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, "R2 R4 bidx disp");
        issue(3'd3, 2'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, "R4 bp base");
        issue(3'd3, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, "R4 bx base");
        // R5: every override
        for (int o = 0; o < 4; o++)
            issue(3'd1, 2'd0, 1'b1, 1'b0, 16'h0010, 1'b0, 1'b1, 2'(o), 1'b0, 1'b0, "R5");
        // R6: string destination beats override
        issue(3'd0, 2'd1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, "R6");
        // R1: 20-bit wrap
        seg_ds = 16'hFFFF;
        issue(3'd5, 2'd0, 1'b0, 1'b0, 16'h0010, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, "R1 wrap");
        // R8: split across the top of memory
        seg_ds = 16'hF000;
        issue(3'd5, 2'd0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, "R8 wrap split");
        // R7: even word
        issue(3'd5, 2'd0, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, "R7 even word");
        // R8 back to back splits
        for (int k = 0; k < 3; k++)
            issue(3'd5, 2'd0, 1'b0, 1'b0, 16'h0101 + 16'(k * 2), 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, "R8 R9 chain");

        // random traffic
        for (int n = 0; n < 2500; n++) begin
            reg_bx = 16'($urandom); reg_bp = 16'($urandom);
            reg_si = 16'($urandom); reg_di = 16'($urandom);
            seg_es = 16'($urandom); seg_cs = 16'($urandom);
            seg_ss = 16'($urandom); seg_ds = 16'($urandom);
            issue(3'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                  1'($urandom), ($urandom % 4) == 0, 2'($urandom), ($urandom % 8) == 0,
                  1'($urandom), "R1 R2 R4 R5 R6 R7 R8 random");
            if ($urandom % 4 == 0) @(negedge clk);
        end

        repeat (10) @(negedge clk);
        chk(rd_ptr == wr_ptr, "R7 all expected beats seen", rd_ptr, wr_ptr);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule